// File: doc/BRIEF.md
# Snapshot-Buffered Timekeeper Register Interface

This block is the register side of a real-time clock. It sits between a byte-level serial slave front end, which decodes bus conditions into single-cycle strobes, and a timekeeping core that counts seconds through years. It owns a sixteen-byte register space addressed by a pointer. The pointer is loaded by an address strobe and advances by one after every byte read and every acknowledged byte write, wrapping from 0Fh to 00h.

The seven time and date bytes (00h to 06h) are never read straight from the running counters. A frozen copy of all seven bytes is taken in one clock cycle on a bus START, on a bus STOP, or when the pointer steps from 0Fh to 00h. Reads return this copy, so a multi-byte read stays consistent while the core keeps counting. A write to a time byte is held until the byte is acknowledged and is then handed to the core as a one-cycle write command. A write to the seconds byte also pulses a reset of the sub-second divider, so that the next 1 Hz edge falls half a second later. The alarm, control and status bytes (07h to 0Fh) live in this block and are read directly.

Top module: `rtc_regif`

## Requirements
- R1: After reset the read data is 00h, no core write or divider reset is issued, the control byte (0Eh) reads 18h, the status byte (0Fh) reads 80h, and the alarm bytes and the time copy hold 00h.
- R2: An address strobe loads the pointer. The pointer advances by one after each read strobe and after each acknowledged write, and steps from 0Fh to 00h.
- R3: A read of 00h..06h returns the time copy. A change on the live time input after the last refresh does not show in the read data.
- R4: The time copy is refreshed from the live input on START, on STOP, and on a pointer step from 0Fh to 00h, whether that step comes from a read or a write. All seven bytes are taken in the same cycle.
- R5: A written byte takes effect only on its acknowledge strobe. For addresses 00h..06h the core write enable pulses for one cycle after the acknowledge, carrying the byte index (0 = seconds .. 6 = year) and the masked data. No write is issued before the acknowledge.
- R6: The divider reset pulses for one cycle together with the core write of byte 0 (seconds), and only for that byte.
- R7: Unused bits always read and pass as zero. The masks are: seconds 7Fh, minutes 7Fh, hours 7Fh, day 07h, date 3Fh, month 9Fh, year FFh, alarms FFh, control 9Fh (bits 6:5 zero), status 83h (bits 6:2 zero). Status set inputs outside bits 7, 1 and 0 are ignored.
- R8: Bytes 07h..0Fh read their stored value at once, with no START or STOP needed after a write.
- R9: Writing 0 to a status bit clears it and writing 1 leaves it unchanged. A set input sets its bit and wins over a clear in the same cycle.
- R10: The seven alarm bytes (07h..0Dh) appear on the alarm output (07h in the lowest byte), and the control byte appears on the control output, one cycle after the write is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_start_i | input | 1 | START (or repeated START) seen on the bus |
| bus_stop_i | input | 1 | STOP seen on the bus |
| addr_ld_i | input | 1 | Load the pointer from addr_i |
| addr_i | input | 4 | Register address to load |
| wbyte_i | input | 1 | A write byte has arrived on wdata_i |
| wdata_i | input | 8 | Write byte |
| wack_i | input | 1 | The pending write byte is acknowledged |
| rbyte_i | input | 1 | A read byte is requested |
| rdata_o | output | 8 | Byte read at the pointer, registered |
| live_time_i | input | 56 | Running time bytes from the core, byte 0 = seconds |
| core_we_o | output | 1 | One-cycle write command to the core |
| core_widx_o | output | 3 | Time byte index of the write |
| core_wdata_o | output | 8 | Masked time byte being written |
| div_rst_o | output | 1 | Sub-second divider reset pulse |
| stat_set_i | input | 8 | Per-bit set requests for the status byte |
| alarm_o | output | 56 | Alarm bytes 07h..0Dh |
| ctrl_o | output | 8 | Control byte |
| stat_o | output | 8 | Status byte |

## Verification
Multi-byte reads are run with the live time changed after the copy was taken. Stale and fresh values then differ, so a design that reads the live input or never refreshes the copy is exposed. Refreshes are triggered separately by STOP followed by START, by a read-driven wrap and by a write-driven wrap, and the live value is changed around each event, which separates refresh timing from pointer bugs. Writes are checked before and after their acknowledge, to seconds and to minutes, so early commits and wrong divider-reset decoding show. Status writes of 0 and of 1, mixed with set pulses and with ignored bit positions, separate clear-on-zero from plain overwrite.

// File: rtl/rtc_regif_pkg.sv
// Shared constants and helpers for the timekeeper register interface.
// Assumes an 8-bit register byte and a 16-entry address space.
package rtc_regif_pkg;

    localparam int unsigned REG_W  = 8;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned NREG   = 1 << ADDR_W;
    localparam int unsigned TIME_N = 7;
    localparam int unsigned KEEP_N = NREG - TIME_N;

    // Mask of implemented bits for each register address.
    function automatic logic [REG_W-1:0] reg_mask(input int unsigned a);
        logic [REG_W-1:0] m;
        case (a)
            0, 1, 2: m = 8'h7F;
            3:       m = 8'h07;
            4:       m = 8'h3F;
            5:       m = 8'h9F;
            14:      m = 8'h9F;
            15:      m = 8'h83;
            default: m = 8'hFF;
        endcase
        return m;
    endfunction

    // One acknowledged write, as handed between sub-blocks.
    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [REG_W-1:0]  data;
    } wcmd_t;

endpackage

// File: rtl/rtc_regif_ptr.sv
// Auto-incrementing register pointer.
// Loads on ld_i, advances on step_i, wraps from all-ones to zero.
// Assumes ld_i and step_i are never asserted together.
module rtc_regif_ptr #(
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_i,
    input  logic [ADDR_W-1:0] ld_val_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              wrap_o
);
    localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] ptr_q;

    // Pointer register: load, step, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (ld_i) begin
            ptr_q <= ld_val_i;
        end else if (step_i) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    // The step in progress takes the pointer back to zero.
    always_comb wrap_o = step_i && !ld_i && (ptr_q == LAST);

    assign ptr_o = ptr_q;
endmodule

// File: rtl/rtc_regif_snap.sv
// Secondary copy of the time and date bytes.
// All bytes are captured from the live input in the same clock edge when
// refresh_i is high; unused bits are dropped on capture.
module rtc_regif_snap #(
    parameter int unsigned TIME_N = 7,
    parameter int unsigned REG_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    refresh_i,
    input  logic [TIME_N*REG_W-1:0] live_i,
    output logic [TIME_N*REG_W-1:0] snap_o
);
    import rtc_regif_pkg::*;

    for (genvar i = 0; i < TIME_N; i++) begin : g_byte
        localparam logic [REG_W-1:0] MASK = reg_mask(i);
        logic [REG_W-1:0] q;

        // Capture one masked time byte on refresh.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (refresh_i) begin
                q <= live_i[i*REG_W +: REG_W] & MASK;
            end
        end

        assign snap_o[i*REG_W +: REG_W] = q;
    end
endmodule

// File: rtl/rtc_regif_bank.sv
// Locally stored bytes above the time range: alarms, control, status.
// The last entry is the status byte: written zeros clear its bits, written
// ones are ignored, and set requests win. The entry before it is control.
// Index i here corresponds to register address BASE+i.
module rtc_regif_bank #(
    parameter int unsigned   KEEP_N   = 9,
    parameter int unsigned   BASE     = 7,
    parameter int unsigned   REG_W    = 8,
    parameter int unsigned   ADDR_W   = 4,
    parameter logic [7:0]    CTRL_RST = 8'h18,
    parameter logic [7:0]    STAT_RST = 8'h80
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we_i,
    input  logic [ADDR_W-1:0]       widx_i,
    input  logic [REG_W-1:0]        wdata_i,
    input  logic [REG_W-1:0]        stat_set_i,
    output logic [KEEP_N*REG_W-1:0] bank_o
);
    import rtc_regif_pkg::*;

    localparam int unsigned STAT_IDX = KEEP_N - 1;
    localparam int unsigned CTRL_IDX = KEEP_N - 2;

    for (genvar i = 0; i < KEEP_N; i++) begin : g_ent
        localparam logic [REG_W-1:0] MASK = reg_mask(BASE + i);
        localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
        logic [REG_W-1:0] q;
        logic             hit;

        assign hit = we_i && (widx_i == IDX);

        if (i == STAT_IDX) begin : g_stat
            // Status: clear-on-zero writes, then OR in set requests.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= STAT_RST & MASK;
                end else begin
                    q <= (hit ? (q & wdata_i) : q) | (stat_set_i & MASK);
                end
            end
        end else begin : g_plain
            localparam logic [REG_W-1:0] RST = (i == CTRL_IDX) ? CTRL_RST : '0;
            // Plain byte: masked overwrite on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= RST & MASK;
                end else if (hit) begin
                    q <= wdata_i & MASK;
                end
            end
        end

        assign bank_o[i*REG_W +: REG_W] = q;
    end
endmodule

// File: rtl/rtc_regif.sv
// Timekeeper register interface: pointer, time copy, write hand-off.
// Assumes the serial front end gives at most one of start, stop, address
// load, write byte, acknowledge and read byte in any cycle.
module rtc_regif #(
    parameter logic [7:0] CTRL_RST = 8'h18,
    parameter logic [7:0] STAT_RST = 8'h80
) (
    input  logic                                                   clk,
    input  logic                                                   rst_n,
    input  logic                                                   bus_start_i,
    input  logic                                                   bus_stop_i,
    input  logic                                                   addr_ld_i,
    input  logic [rtc_regif_pkg::ADDR_W-1:0]                       addr_i,
    input  logic                                                   wbyte_i,
    input  logic [rtc_regif_pkg::REG_W-1:0]                        wdata_i,
    input  logic                                                   wack_i,
    input  logic                                                   rbyte_i,
    output logic [rtc_regif_pkg::REG_W-1:0]                        rdata_o,
    input  logic [rtc_regif_pkg::TIME_N*rtc_regif_pkg::REG_W-1:0]  live_time_i,
    output logic                                                   core_we_o,
    output logic [$clog2(rtc_regif_pkg::TIME_N)-1:0]               core_widx_o,
    output logic [rtc_regif_pkg::REG_W-1:0]                        core_wdata_o,
    output logic                                                   div_rst_o,
    input  logic [rtc_regif_pkg::REG_W-1:0]                        stat_set_i,
    output logic [(rtc_regif_pkg::KEEP_N-2)*rtc_regif_pkg::REG_W-1:0] alarm_o,
    output logic [rtc_regif_pkg::REG_W-1:0]                        ctrl_o,
    output logic [rtc_regif_pkg::REG_W-1:0]                        stat_o
);
    import rtc_regif_pkg::*;

    localparam int unsigned IDX_W = $clog2(TIME_N);
    localparam logic [ADDR_W-1:0] TIME_LIM = ADDR_W'(TIME_N);
    localparam int unsigned ALARM_N = KEEP_N - 2;

    logic [ADDR_W-1:0]          ptr_q;
    logic                       wrap;
    logic                       refresh;
    logic                       commit;
    logic                       in_time;
    logic [REG_W-1:0]           pend_q;
    logic                       pend_v;
    logic [TIME_N*REG_W-1:0]    snap;
    logic [KEEP_N*REG_W-1:0]    bank;
    logic [REG_W-1:0]           regs [NREG];
    logic [REG_W-1:0]           cur_mask;
    wcmd_t                      bank_cmd;

    // Hold the received write byte until its acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            pend_v <= 1'b0;
        end else if (bus_start_i || bus_stop_i) begin
            pend_v <= 1'b0;
        end else if (wbyte_i) begin
            pend_q <= wdata_i;
            pend_v <= 1'b1;
        end else if (wack_i) begin
            pend_v <= 1'b0;
        end
    end

    assign commit  = wack_i && pend_v;
    assign in_time = (ptr_q < TIME_LIM);
    assign refresh = bus_start_i || bus_stop_i || wrap;

    rtc_regif_ptr #(.ADDR_W(ADDR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_i     (addr_ld_i),
        .ld_val_i (addr_i),
        .step_i   (commit || rbyte_i),
        .ptr_o    (ptr_q),
        .wrap_o   (wrap)
    );

    rtc_regif_snap #(.TIME_N(TIME_N), .REG_W(REG_W)) u_snap (
        .clk       (clk),
        .rst_n     (rst_n),
        .refresh_i (refresh),
        .live_i    (live_time_i),
        .snap_o    (snap)
    );

    // Route acknowledged writes above the time range into the bank.
    always_comb begin
        bank_cmd.en   = commit && !in_time;
        bank_cmd.addr = ADDR_W'(ptr_q - TIME_LIM);
        bank_cmd.data = pend_q;
    end

    rtc_regif_bank #(
        .KEEP_N   (KEEP_N),
        .BASE     (TIME_N),
        .REG_W    (REG_W),
        .ADDR_W   (ADDR_W),
        .CTRL_RST (CTRL_RST),
        .STAT_RST (STAT_RST)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .we_i       (bank_cmd.en),
        .widx_i     (bank_cmd.addr),
        .wdata_i    (bank_cmd.data),
        .stat_set_i (stat_set_i),
        .bank_o     (bank)
    );

    // Flat view of the whole register space for the read mux.
    for (genvar a = 0; a < NREG; a++) begin : g_view
        if (a < TIME_N) begin : g_t
            assign regs[a] = snap[a*REG_W +: REG_W];
        end else begin : g_k
            assign regs[a] = bank[(a-TIME_N)*REG_W +: REG_W];
        end
    end

    // Mask of the byte at the pointer, for time writes.
    always_comb begin
        cur_mask = '1;
        for (int a = 0; a < NREG; a++) begin
            if (ptr_q == ADDR_W'(a)) cur_mask = reg_mask(a);
        end
    end

    // Registered read data, taken before the pointer advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (rbyte_i) begin
            rdata_o <= regs[ptr_q];
        end
    end

    // Hand acknowledged time writes to the core; seconds resets the divider.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_we_o    <= 1'b0;
            core_widx_o  <= '0;
            core_wdata_o <= '0;
            div_rst_o    <= 1'b0;
        end else begin
            core_we_o <= commit && in_time;
            div_rst_o <= commit && (ptr_q == '0);
            if (commit && in_time) begin
                core_widx_o  <= IDX_W'(ptr_q);
                core_wdata_o <= pend_q & cur_mask;
            end
        end
    end

    assign alarm_o = bank[ALARM_N*REG_W-1:0];
    assign ctrl_o  = bank[ALARM_N*REG_W +: REG_W];
    assign stat_o  = bank[(ALARM_N+1)*REG_W +: REG_W];
endmodule

// File: rtl/rtc_regif_chk.sv
// Property checker for the timekeeper register interface, bound to the top.
// Observes ports plus the pointer, refresh strobe and time copy.
module rtc_regif_chk #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DW     = 56
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wack_i,
    input logic              rbyte_i,
    input logic              addr_ld_i,
    input logic              core_we_o,
    input logic [2:0]        core_widx_o,
    input logic              div_rst_o,
    input logic [7:0]        ctrl_o,
    input logic [7:0]        stat_o,
    input logic [7:0]        stat_set_i,
    input logic [ADDR_W-1:0] ptr_q,
    input logic              refresh,
    input logic [DW-1:0]     snap
);
    // R2: a read at the last address brings the pointer back to zero.
    p_ptr_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rbyte_i && !addr_ld_i && ptr_q == {ADDR_W{1'b1}}) |=> (ptr_q == '0));

    // R3: without a refresh event the time copy does not move.
    p_copy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !refresh |=> $stable(snap));

    // R5: every core write follows an acknowledge.
    p_wr_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        core_we_o |-> $past(wack_i));

    // R6: divider reset only comes with a seconds write.
    p_div_seconds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        div_rst_o |-> (core_we_o && core_widx_o == 3'd0));

    // R7: unimplemented control and status bits stay zero.
    p_unused_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o[6:5] == 2'b00) && (stat_o[6:2] == 5'b0));

    // R9: without a set request no status bit rises.
    p_no_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_set_i == 8'h00) |=> ((stat_o & ~$past(stat_o)) == 8'h00));
endmodule

bind rtc_regif rtc_regif_chk #(
    .ADDR_W (rtc_regif_pkg::ADDR_W),
    .DW     (rtc_regif_pkg::TIME_N * rtc_regif_pkg::REG_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wack_i      (wack_i),
    .rbyte_i     (rbyte_i),
    .addr_ld_i   (addr_ld_i),
    .core_we_o   (core_we_o),
    .core_widx_o (core_widx_o),
    .div_rst_o   (div_rst_o),
    .ctrl_o      (ctrl_o),
    .stat_o      (stat_o),
    .stat_set_i  (stat_set_i),
    .ptr_q       (ptr_q),
    .refresh     (refresh),
    .snap        (snap)
);

// File: tb/rtc_regif_tb.sv
// Self-checking bench for the timekeeper register interface.
module rtc_regif_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_start_i = 1'b0, bus_stop_i = 1'b0, addr_ld_i = 1'b0;
    logic [3:0]  addr_i = '0;
    logic        wbyte_i = 1'b0, wack_i = 1'b0, rbyte_i = 1'b0;
    logic [7:0]  wdata_i = '0;
    logic [7:0]  rdata_o;
    logic [55:0] live_time_i;
    logic        core_we_o;
    logic [2:0]  core_widx_o;
    logic [7:0]  core_wdata_o;
    logic        div_rst_o;
    logic [7:0]  stat_set_i = '0;
    logic [55:0] alarm_o;
    logic [7:0]  ctrl_o, stat_o;
    logic [7:0]  live [7];

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 7; i++) live_time_i[i*8 +: 8] = live[i];
    end

    rtc_regif u_dut (
        .clk(clk), .rst_n(rst_n), .bus_start_i(bus_start_i), .bus_stop_i(bus_stop_i),
        .addr_ld_i(addr_ld_i), .addr_i(addr_i), .wbyte_i(wbyte_i), .wdata_i(wdata_i),
        .wack_i(wack_i), .rbyte_i(rbyte_i), .rdata_o(rdata_o), .live_time_i(live_time_i),
        .core_we_o(core_we_o), .core_widx_o(core_widx_o), .core_wdata_o(core_wdata_o),
        .div_rst_o(div_rst_o), .stat_set_i(stat_set_i), .alarm_o(alarm_o),
        .ctrl_o(ctrl_o), .stat_o(stat_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Every strobe is raised at a falling edge and dropped at the next one.
    task automatic ev_start(); bus_start_i = 1; @(negedge clk); bus_start_i = 0; endtask
    task automatic ev_stop();  bus_stop_i  = 1; @(negedge clk); bus_stop_i  = 0; endtask
    task automatic ev_addr(input logic [3:0] a);
        addr_ld_i = 1; addr_i = a; @(negedge clk); addr_ld_i = 0;
    endtask
    task automatic ev_wbyte(input logic [7:0] d);
        wbyte_i = 1; wdata_i = d; @(negedge clk); wbyte_i = 0;
    endtask
    task automatic ev_ack(); wack_i = 1; @(negedge clk); wack_i = 0; endtask
    task automatic ev_write(input logic [7:0] d); ev_wbyte(d); ev_ack(); endtask
    task automatic ev_read(); rbyte_i = 1; @(negedge clk); rbyte_i = 0; endtask

    // Ops: 0 start, 1 stop, 2 address, 3 write, 4 read+check, 5 set live seconds.
    localparam int NV = 23;
    localparam logic [18:0] VEC [NV] = '{
        {3'd0, 8'h00, 8'h00},
        {3'd2, 8'h00, 8'h00},
        {3'd5, 8'h11, 8'h00},
        {3'd4, 8'h00, 8'h05},   // R3 old copy, R7 seconds bit 7 dropped
        {3'd4, 8'h00, 8'h30},
        {3'd4, 8'h00, 8'h12},
        {3'd4, 8'h00, 8'h03},   // R7 day mask
        {3'd4, 8'h00, 8'h15},   // R7 date mask
        {3'd4, 8'h00, 8'h91},
        {3'd4, 8'h00, 8'h24},
        {3'd4, 8'h00, 8'h00},   // R1 alarm byte at 07h after reset
        {3'd1, 8'h00, 8'h00},
        {3'd0, 8'h00, 8'h00},
        {3'd2, 8'h00, 8'h00},
        {3'd4, 8'h00, 8'h11},   // R4 refresh on stop/start
        {3'd2, 8'h0E, 8'h00},
        {3'd3, 8'hFF, 8'h00},
        {3'd2, 8'h0E, 8'h00},
        {3'd4, 8'h00, 8'h9F},   // R8 R7 control readback
        {3'd5, 8'h33, 8'h00},
        {3'd4, 8'h00, 8'h80},   // R1 status, read wraps pointer
        {3'd5, 8'h44, 8'h00},
        {3'd4, 8'h00, 8'h33}    // R4 refresh on read wrap, R2
    };

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        live[0] = 8'h85; live[1] = 8'h30; live[2] = 8'h12; live[3] = 8'hFB;
        live[4] = 8'hD5; live[5] = 8'h91; live[6] = 8'h24;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", rdata_o, 8'h00);
        check("R1 core_we", {core_we_o, div_rst_o}, 2'b00);
        check("R1 ctrl", ctrl_o, 8'h18);
        check("R1 stat", stat_o, 8'h80);
        check("R1 alarms", alarm_o, 56'h0);

        for (int v = 0; v < NV; v++) begin
            case (VEC[v][18:16])
                3'd0: ev_start();
                3'd1: ev_stop();
                3'd2: ev_addr(VEC[v][11:8]);
                3'd3: ev_write(VEC[v][15:8]);
                3'd4: begin
                    ev_read();
                    check($sformatf("R3/R4/R8 vector %0d", v), rdata_o, VEC[v][7:0]);
                end
                default: begin live[0] = VEC[v][15:8]; @(negedge clk); end
            endcase
        end

        // R5 R6: seconds write, no commit before acknowledge
        ev_addr(4'h0);
        ev_wbyte(8'hD9);
        check("R5 no write before ack", core_we_o, 1'b0);
        ev_ack();
        check("R5 write enable", core_we_o, 1'b1);
        check("R5 index", core_widx_o, 3'd0);
        check("R5 R7 masked data", core_wdata_o, 8'h59);
        check("R6 divider reset", div_rst_o, 1'b1);
        @(negedge clk);
        check("R5 one-cycle pulse", {core_we_o, div_rst_o}, 2'b00);
        ev_write(8'h45);
        check("R5 minutes index", core_widx_o, 3'd1);
        check("R6 no reset for minutes", div_rst_o, 1'b0);

        // R9 status set and clear rules
        stat_set_i = 8'h03; @(negedge clk); stat_set_i = 8'h00;
        check("R9 set inputs", stat_o, 8'h83);
        ev_addr(4'hF); ev_write(8'h02);
        check("R9 zero clears", stat_o, 8'h02);
        ev_addr(4'hF); ev_write(8'hFF);
        check("R9 one no effect", stat_o, 8'h02);
        stat_set_i = 8'h10; @(negedge clk); stat_set_i = 8'h00;
        check("R7 ignored set bit", stat_o, 8'h02);

        // R10 R8 alarm byte
        ev_addr(4'h7); ev_write(8'hA5);
        check("R10 alarm out", alarm_o[7:0], 8'hA5);
        check("R10 control out", ctrl_o, 8'h9F);
        ev_addr(4'h7); ev_read();
        check("R8 alarm direct read", rdata_o, 8'hA5);

        // R2 pointer load
        ev_addr(4'h3); ev_read();
        check("R2 pointer load", rdata_o, 8'h03);

        // R4 R2 refresh on a write-driven wrap
        live[0] = 8'h57;
        ev_addr(4'hF); ev_write(8'hFF);
        live[0] = 8'h01;
        ev_read();
        check("R4 write wrap refresh", rdata_o, 8'h57);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule